// File: doc/BRIEF.md
# I2C Target Receiver with Clock Stretching

This block is the receive side of an I2C target. It samples the SCL and SDA lines in the system clock domain and tracks start and stop conditions to keep a bus-busy flag. It compares the first frame after every start with a 7-bit own address supplied on a port. When that frame matches and asks for a write, the block acknowledges it and every data byte that follows until the next start or stop.

Received bytes go to a one-byte data register that a processor reads with a strobe. Each completed frame that the block accepts sets a sticky interrupt flag, and data bytes also set a receive-full flag. The processor clears the interrupt flag with a separate strobe. If a data byte completes while the previous one is still unread, the block accepts the new byte and then holds SCL low after the acknowledge clock. It releases SCL once the processor has read the older byte. Both bus outputs are active-high pull-low enables for open-drain pads.

Top module: `i2c_slave_rx`

## Requirements
- R1: A start condition (SDA falling while SCL is high) sets `bus_busy` to 1 while the block is enabled, and every start restarts address comparison.
- R2: A stop condition (SDA rising while SCL is high) clears `bus_busy` to 0.
- R3: When the first frame after a start holds the own address in its upper seven bits and a 0 in its last bit (write), the block drives SDA low for the ninth clock and raises `addressed`.
- R4: When that frame carries another address, or a 1 in its last bit, the block leaves SDA released. It then also leaves SDA released for every later frame, and `rx_full` stays unchanged, until the next start. A repeated start with the own address is acknowledged again.
- R5: While addressed, each received data byte (first bit on the wire is the MSB) is acknowledged on the ninth clock, appears on `rd_data`, and sets `rx_full` when it was 0.
- R6: The interrupt flag `irq_flag` is set at the acknowledge of the matching address frame and of every data byte. The output `irq` equals `irq_flag` AND `irq_en`.
- R7: `irq_flag` stays set until `irq_clr` is pulsed. Reading data does not clear it.
- R8: A pulse on `rd_strobe` with `rx_full` at 1 and no byte waiting clears `rx_full`.
- R9: A data byte that completes while `rx_full` is 1 is still acknowledged and is then held back. From the falling edge that ends its ninth clock, the block pulls SCL low until `rd_strobe`. That read returns the older byte, after which the new byte appears on `rd_data`, `rx_full` stays 1 and SCL is released.
- R10: With `en` at 0 the block releases both lines, keeps `bus_busy` at 0 and acknowledges nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| irq_en | input | 1 | Interrupt request enable |
| own_addr | input | 7 | Own target address |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| rd_strobe | input | 1 | One-cycle read of the data register |
| rd_data | output | 8 | Data register contents |
| irq_clr | input | 1 | One-cycle clear of the interrupt flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Interrupt request |
| rx_full | output | 1 | Receive-full flag |
| bus_busy | output | 1 | Bus-busy flag |
| addressed | output | 1 | Block is the addressed target of the current transfer |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default of 2. This adds one cycle of latency between a line change and the block's reaction. A bus master in the bench runs SCL at 40 system clocks per period and waits whenever SCL is held low. That setup exercises acknowledge timing, stretch entry and stretch release with the longer synchronizer. Together with seeded random addresses, directions and byte counts, it reaches back-to-back unread bytes, repeated starts and ignored frames.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic frame_hits(input logic [BYTE_W-1:0] frame,
                                        input logic [ADDR_W-1:0] own);
        return (frame[BYTE_W-1:1] == own) && !frame[0];
    endfunction
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync
    import i2c_srx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_q, sda_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_pipe[STAGES-1];
            sda_q <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_pipe[STAGES-1];
        ev.sda      = sda_pipe[STAGES-1];
        ev.scl_rise = ev.scl && !scl_q;
        ev.scl_fall = !ev.scl && scl_q;
        ev.start    = ev.scl && scl_q && sda_q && !ev.sda;
        ev.stop     = ev.scl && scl_q && !sda_q && ev.sda;
    end
endmodule

// File: rtl/i2c_srx_frame.sv
module i2c_srx_frame
    import i2c_srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              byte_waiting,
    output logic              bus_busy,
    output logic              addressed,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              addr_ok
);
    phase_e            phase;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              in_ack;
    logic              active;
    logic              frame_end;

    assign active    = (phase == PH_ADDR) || (phase == PH_DATA);
    assign frame_end = ev.scl_fall && !in_ack && (bitcnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase     <= PH_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            in_ack    <= 1'b0;
            bus_busy  <= 1'b0;
            addressed <= 1'b0;
            sda_pull  <= 1'b0;
            scl_pull  <= 1'b0;
            byte_done <= 1'b0;
            byte_val  <= '0;
            addr_ok   <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            addr_ok   <= 1'b0;
            if (ev.start) begin
                bus_busy  <= 1'b1;
                phase     <= PH_ADDR;
                bitcnt    <= '0;
                in_ack    <= 1'b0;
                addressed <= 1'b0;
                sda_pull  <= 1'b0;
            end else if (ev.stop) begin
                bus_busy  <= 1'b0;
                phase     <= PH_IDLE;
                bitcnt    <= '0;
                in_ack    <= 1'b0;
                addressed <= 1'b0;
                sda_pull  <= 1'b0;
            end else if (active) begin
                if (ev.scl_rise && !in_ack && bitcnt < CNT_W'(BYTE_W)) begin
                    shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                    bitcnt <= bitcnt + 1'b1;
                end else if (frame_end) begin
                    if (phase == PH_ADDR) begin
                        if (frame_hits(shreg, own_addr)) begin
                            in_ack    <= 1'b1;
                            sda_pull  <= 1'b1;
                            addr_ok   <= 1'b1;
                            addressed <= 1'b1;
                        end else begin
                            phase  <= PH_SKIP;
                            bitcnt <= '0;
                        end
                    end else begin
                        in_ack    <= 1'b1;
                        sda_pull  <= 1'b1;
                        byte_done <= 1'b1;
                        byte_val  <= shreg;
                    end
                end else if (ev.scl_fall && in_ack) begin
                    in_ack   <= 1'b0;
                    sda_pull <= 1'b0;
                    bitcnt   <= '0;
                    if (phase == PH_ADDR) phase <= PH_DATA;
                    if (phase == PH_DATA && byte_waiting) scl_pull <= 1'b1;
                end
            end
            if (scl_pull && !byte_waiting) scl_pull <= 1'b0;
        end
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst || !en)
        ev.start |=> bus_busy); // R1
    AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst || !en)
        ev.stop |=> !bus_busy); // R2
    AST_SKIP_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !sda_pull); // R4
endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
    import i2c_srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              addr_ok,
    input  logic              rd_strobe,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] data_q,
    output logic              rx_full,
    output logic              byte_waiting,
    output logic              irq_flag
);
    logic [BYTE_W-1:0] held_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q       <= '0;
            held_byte    <= '0;
            rx_full      <= 1'b0;
            byte_waiting <= 1'b0;
        end else if (byte_done) begin
            if (rx_full && !rd_strobe) begin
                byte_waiting <= 1'b1;
                held_byte    <= byte_val;
            end else begin
                data_q  <= byte_val;
                rx_full <= 1'b1;
            end
        end else if (rd_strobe) begin
            if (byte_waiting) begin
                data_q       <= held_byte;
                rx_full      <= 1'b1;
                byte_waiting <= 1'b0;
            end else begin
                rx_full <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                      irq_flag <= 1'b0;
        else if (byte_done || addr_ok) irq_flag <= 1'b1;
        else if (irq_clr)             irq_flag <= 1'b0;
    end

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rx_full && !byte_waiting && !byte_done) |=> !rx_full); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag); // R7
    AST_WAIT_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        byte_waiting |-> rx_full); // R9
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
    import i2c_srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              rd_strobe,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              irq_clr,
    output logic              irq_flag,
    output logic              irq,
    output logic              rx_full,
    output logic              bus_busy,
    output logic              addressed
);
    bus_ev_t           ev;
    logic              byte_done, addr_ok, byte_waiting;
    logic [BYTE_W-1:0] byte_val;

    i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_in), .sda_i(sda_in), .ev(ev)
    );

    i2c_srx_frame u_frame (
        .clk(clk), .rst(rst), .en(en), .ev(ev), .own_addr(own_addr),
        .byte_waiting(byte_waiting), .bus_busy(bus_busy), .addressed(addressed),
        .sda_pull(sda_pull), .scl_pull(scl_pull), .byte_done(byte_done),
        .byte_val(byte_val), .addr_ok(addr_ok)
    );

    i2c_srx_regs u_regs (
        .clk(clk), .rst(rst), .byte_done(byte_done), .byte_val(byte_val),
        .addr_ok(addr_ok), .rd_strobe(rd_strobe), .irq_clr(irq_clr),
        .data_q(rd_data), .rx_full(rx_full), .byte_waiting(byte_waiting),
        .irq_flag(irq_flag)
    );

    assign irq = irq_flag && irq_en;

    AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sda_pull && !scl_pull && !bus_busy)); // R10
    AST_HOLD_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        scl_pull |-> rx_full); // R9
endmodule

// File: tb/i2c_slave_rx_bench.sv
module i2c_slave_rx_bench;
    localparam int Q = 10;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, en, irq_en, rd_strobe, irq_clr;
    logic [6:0] own_addr;
    logic scl_m, sda_m;
    logic scl_pull, sda_pull, irq_flag, irq, rx_full, bus_busy, addressed;
    logic [7:0] rd_data;
    logic scl_bus, sda_bus;

    assign scl_bus = scl_m & ~scl_pull;
    assign sda_bus = sda_m & ~sda_pull;

    int checks = 0;
    int errors = 0;

    i2c_slave_rx #(.SYNC_STAGES(3)) u_i2c_slave_rx (
        .clk(clk), .rst(rst), .en(en), .irq_en(irq_en), .own_addr(own_addr),
        .scl_in(scl_bus), .sda_in(sda_bus), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .irq_clr(irq_clr),
        .irq_flag(irq_flag), .irq(irq), .rx_full(rx_full), .bus_busy(bus_busy),
        .addressed(addressed)
    );

    function automatic logic exp_ack(input logic [6:0] a, input logic rw);
        return (a == OWN) && !rw;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        @(negedge clk);
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; cyc(Q);
        scl_up(); cyc(Q);
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; cyc(Q);
        scl_up(); cyc(Q);
        sda_m = 1'b1; cyc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; cyc(Q);
            scl_up(); cyc(2 * Q);
            scl_m = 1'b0; cyc(Q);
        end
        sda_m = 1'b1; cyc(Q);
        scl_up(); cyc(Q);
        ack = !sda_bus;
        cyc(Q);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk);
        v = rd_data;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        cyc(2);
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        cyc(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int seed;
        rst = 1'b1; en = 1'b1; irq_en = 1'b1; own_addr = OWN;
        rd_strobe = 1'b0; irq_clr = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        cyc(5);
        rst = 1'b0;
        cyc(5);
        chk(!bus_busy && !rx_full && !irq_flag && !sda_pull && !scl_pull,
            "R1 reset state", {bus_busy, rx_full, irq_flag, sda_pull, scl_pull}, 0);

        // basic write transfer
        bus_start();
        chk(bus_busy, "R1 busy after start", bus_busy, 1);
        send_byte({OWN, 1'b0}, ack);
        chk(ack, "R3 address ack", ack, 1);
        chk(addressed, "R3 addressed", addressed, 1);
        chk(irq_flag && irq, "R6 flag on address", {irq_flag, irq}, 3);
        chk(!rx_full, "R5 address not stored", rx_full, 0);
        pulse_clr();
        chk(!irq_flag, "R7 clear strobe", irq_flag, 0);
        send_byte(8'hA5, ack);
        chk(ack, "R5 data ack", ack, 1);
        chk(rx_full && rd_data == 8'hA5, "R5 data stored", {rx_full, rd_data}, 9'h1A5);
        do_read(v);
        chk(v == 8'hA5, "R5 read value", v, 8'hA5);
        chk(!rx_full, "R8 read clears full", rx_full, 0);
        cyc(50);
        chk(irq_flag, "R7 flag sticky after read", irq_flag, 1);
        pulse_clr();
        bus_stop();
        cyc(5);
        chk(!bus_busy, "R2 busy after stop", bus_busy, 0);

        // stretch on unread byte
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        chk(ack, "R9 second byte acked", ack, 1);
        cyc(20);
        chk(scl_pull, "R9 SCL held", scl_pull, 1);
        chk(rd_data == 8'h11, "R9 old byte visible", rd_data, 8'h11);
        do_read(v);
        chk(v == 8'h11, "R9 read returns old byte", v, 8'h11);
        cyc(5);
        chk(!scl_pull && rx_full && rd_data == 8'h22, "R9 release and load",
            {scl_pull, rx_full, rd_data}, 10'h122);
        do_read(v);
        chk(v == 8'h22 && !rx_full, "R9 second read", {rx_full, v}, 9'h022);
        bus_stop();
        pulse_clr();

        // address mismatch, then repeated start
        bus_start();
        send_byte({7'h33, 1'b0}, ack);
        chk(!ack && !addressed, "R4 mismatch no ack", {ack, addressed}, 0);
        send_byte(8'h77, ack);
        chk(!ack && !rx_full, "R4 data ignored", {ack, rx_full}, 0);
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        chk(ack, "R4 repeated start matches", ack, 1);
        send_byte(8'h3C, ack);
        do_read(v);
        chk(ack && v == 8'h3C, "R4 data after repeated start", {ack, v}, 9'h13C);
        bus_stop();

        // read direction is not acknowledged
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        chk(!ack, "R4 read direction no ack", ack, 0);
        bus_stop();
        pulse_clr();

        // interrupt enable gating
        irq_en = 1'b0;
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        send_byte(8'h5E, ack);
        chk(irq_flag && !irq, "R6 irq gated", {irq_flag, irq}, 2);
        irq_en = 1'b1;
        cyc(2);
        chk(irq, "R6 irq enabled", irq, 1);
        do_read(v);
        bus_stop();
        pulse_clr();

        // disabled
        en = 1'b0;
        bus_start();
        chk(!bus_busy, "R10 no busy when off", bus_busy, 0);
        send_byte({OWN, 1'b0}, ack);
        chk(!ack && !irq_flag, "R10 no ack when off", {ack, irq_flag}, 0);
        bus_stop();
        en = 1'b1;
        cyc(5);

        // seeded random transfers
        seed = $urandom(32'd20240611);
        for (int t = 0; t < 20; t++) begin
            logic [6:0] a;
            logic rw;
            logic exp;
            int nb;
            a  = ($urandom % 2 == 0) ? OWN : 7'($urandom);
            rw = ($urandom % 5 == 0);
            nb = 1 + ($urandom % 3);
            exp = exp_ack(a, rw);
            bus_start();
            send_byte({a, rw}, ack);
            chk(ack == exp, "R3 random address", ack, exp);
            for (int k = 0; k < nb; k++) begin
                logic [7:0] d;
                d = 8'($urandom);
                send_byte(d, ack);
                chk(ack == exp, "R5 random data ack", ack, exp);
                if (exp) begin
                    do_read(v);
                    chk(v == d, "R5 random data value", v, d);
                end else begin
                    chk(!rx_full, "R4 random ignored", rx_full, 0);
                end
            end
            bus_stop();
            cyc(5);
            chk(!bus_busy, "R2 random stop", bus_busy, 0);
            pulse_clr();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule